// File: doc/BRIEF.md
# Exclusive, Ordered and Compare-and-Swap Access Decoder

This block sits in the decode stage of a 64-bit load/store pipeline and classifies one instruction word from the load/store class that covers exclusive loads and stores, single-copy ordered loads and stores (load-acquire and store-release), and compare-and-swap in single and paired form. It pulls out the register fields and the access size. It also reports the ordering semantics as acquire/release flags and as barrier requests placed before or after the access. Any encoding that no legal instruction occupies is flagged as undefined.

The dispatch key is a 4-bit index made from instruction bits [23:21] and the ordering bit 15. Exclusive-pair and compare-and-swap-pair instructions share four index values, and bit 31 of the size field separates them. Compare-and-swap forms exist only when the atomics feature input is set. A base register number of 31 means the stack pointer, and the decoder then asks for a stack-alignment check. Each decode is captured in a register, so the results appear one clock after the instruction is presented.

Top module: `xo_decode_top`

## Requirements
- R1: Fields are taken as Rt = insn[4:0], Rn = insn[9:5], Rt2 = insn[14:10], Rs = insn[20:16], size = insn[31:30]. The index is {insn[23:21], insn[15]}. The size output equals insn[31:30] except for the compare-and-swap pair.
- R2: Index 0 or 1 decodes as store-exclusive (op code 1). Release and the before-access barrier both equal insn[15].
- R3: Index 4 or 5 decodes as load-exclusive (op code 2). Acquire and the after-access barrier both equal insn[15].
- R4: Index 9 decodes as store-release (op code 3), with release and the before-access barrier set. Index 13 decodes as load-acquire (op code 4), with acquire and the after-access barrier set.
- R5: Index 2 or 3 with insn[31] = 1 decodes as a store-exclusive pair (op 1). Index 6 or 7 with insn[31] = 1 decodes as a load-exclusive pair (op 2). Both set the pair flag and use the ordering of R2/R3.
- R6: Index 2, 3, 6 or 7 with insn[31] = 0 decodes as a compare-and-swap pair (op code 6, pair flag set, size output {1, insn[30]}). This holds only when Rt2 = 31, Rt and Rs are both even, and the atomics input is set.
- R7: Index 10, 11, 14 or 15 decodes as a single compare-and-swap (op code 5). This holds only when Rt2 = 31 and the atomics input is set.
- R8: Both compare-and-swap forms report acquire = insn[22] and release = insn[15], and they request no barrier.
- R9: Indices 8 and 12, and every compare-and-swap encoding that fails its legality test, set the undefined flag. The op code is then 0 and the pair, acquire, release, barrier and stack-check flags are all 0.
- R10: The stack-alignment check is set exactly when the instruction is defined and Rn = 31.
- R11: All outputs are registered. The results of an instruction presented with the valid input high appear on the next clock edge, together with a one-cycle output-valid pulse. Outputs hold when the valid input is low, and reset clears everything to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is present |
| in_insn | input | 32 | Instruction word |
| in_atomics_en | input | 1 | Atomics feature enable |
| out_valid | output | 1 | Decode result valid (one cycle after in_valid) |
| out_op | output | 3 | Op: 0 none, 1 store-excl, 2 load-excl, 3 store-release, 4 load-acquire, 5 CAS, 6 CAS pair |
| out_undef | output | 1 | Undefined instruction |
| out_pair | output | 1 | Paired register access |
| out_acq | output | 1 | Acquire semantics |
| out_rel | output | 1 | Release semantics |
| out_bar_pre | output | 1 | Barrier requested before the access |
| out_bar_post | output | 1 | Barrier requested after the access |
| out_sp_chk | output | 1 | Stack-pointer alignment check |
| out_rt | output | 5 | Transfer register |
| out_rn | output | 5 | Base register |
| out_rt2 | output | 5 | Second transfer register field |
| out_rs | output | 5 | Status / compare register |
| out_size | output | 2 | Effective access size code |

## Verification
Random words cover all sixteen index values with every size value. Rt2 is forced to 31 about half the time, Rt and Rs are made even about half the time, and the atomics input is mostly set. This mix lets the size bit decide between exclusive pair and compare-and-swap pair, and it drives each legality test through both its pass and fail outcomes. Directed words aim at single failures: an odd Rt, an odd Rs, Rt2 not 31, the feature disabled, indices 8 and 12, and base register 31. Each of these shows whether that one condition alone moves the decode to undefined, or alone raises the stack check. A final idle cycle with a changed word confirms that the registered outputs hold.

// File: rtl/xo_pkg.sv
package xo_pkg;
    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int SIZE_W = 2;
    localparam int IDX_W  = 4;
    localparam logic [REG_W-1:0] SP_REG = '1;

    typedef enum logic [2:0] {
        XO_NONE    = 3'd0,
        XO_ST_EXCL = 3'd1,
        XO_LD_EXCL = 3'd2,
        XO_ST_REL  = 3'd3,
        XO_LD_ACQ  = 3'd4,
        XO_CAS     = 3'd5,
        XO_CASP    = 3'd6
    } xo_op_e;

    typedef struct packed {
        logic              valid;
        xo_op_e            op;
        logic              undef;
        logic              pair;
        logic              acq;
        logic              rel;
        logic              bar_pre;
        logic              bar_post;
        logic              sp_chk;
        logic [REG_W-1:0]  rt;
        logic [REG_W-1:0]  rn;
        logic [REG_W-1:0]  rt2;
        logic [REG_W-1:0]  rs;
        logic [SIZE_W-1:0] size;
    } xo_dec_t;
endpackage

// File: rtl/xo_class_decode.sv
module xo_class_decode
    import xo_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [SIZE_W-1:0] size,
    input  logic [REG_W-1:0]  rt,
    input  logic [REG_W-1:0]  rs,
    input  logic [REG_W-1:0]  rt2,
    input  logic              feat_en,
    output xo_op_e            op,
    output logic              undef,
    output logic              pair,
    output logic [SIZE_W-1:0] eff_size
);
    logic   legal;
    xo_op_e op_raw;
    logic   pair_raw;

    always_comb begin
        legal    = 1'b0;
        op_raw   = XO_NONE;
        pair_raw = 1'b0;
        eff_size = size;
        case (idx)
            4'd0, 4'd1: begin
                op_raw = XO_ST_EXCL;
                legal  = 1'b1;
            end
            4'd4, 4'd5: begin
                op_raw = XO_LD_EXCL;
                legal  = 1'b1;
            end
            4'd9: begin
                op_raw = XO_ST_REL;
                legal  = 1'b1;
            end
            4'd13: begin
                op_raw = XO_LD_ACQ;
                legal  = 1'b1;
            end
            4'd2, 4'd3, 4'd6, 4'd7: begin
                if (size[1]) begin
                    op_raw   = idx[2] ? XO_LD_EXCL : XO_ST_EXCL;
                    pair_raw = 1'b1;
                    legal    = 1'b1;
                end else if (rt2 == SP_REG && !rt[0] && !rs[0] && feat_en) begin
                    op_raw   = XO_CASP;
                    pair_raw = 1'b1;
                    eff_size = {1'b1, size[0]};
                    legal    = 1'b1;
                end
            end
            4'd10, 4'd11, 4'd14, 4'd15: begin
                if (rt2 == SP_REG && feat_en) begin
                    op_raw = XO_CAS;
                    legal  = 1'b1;
                end
            end
            default: legal = 1'b0;
        endcase
        undef = !legal;
        op    = legal ? op_raw : XO_NONE;
        pair  = legal && pair_raw;
    end
endmodule

// File: rtl/xo_order_ctl.sv
module xo_order_ctl
    import xo_pkg::*;
(
    input  xo_op_e op,
    input  logic   ord_bit,
    input  logic   load_bit,
    output logic   acq,
    output logic   rel,
    output logic   bar_pre,
    output logic   bar_post
);
    always_comb begin
        acq      = 1'b0;
        rel      = 1'b0;
        bar_pre  = 1'b0;
        bar_post = 1'b0;
        case (op)
            XO_ST_EXCL, XO_ST_REL: begin
                rel     = ord_bit;
                bar_pre = ord_bit;
            end
            XO_LD_EXCL, XO_LD_ACQ: begin
                acq      = ord_bit;
                bar_post = ord_bit;
            end
            XO_CAS, XO_CASP: begin
                acq = load_bit;
                rel = ord_bit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xo_decode_top.sv
module xo_decode_top
    import xo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  logic              in_atomics_en,
    output logic              out_valid,
    output logic [2:0]        out_op,
    output logic              out_undef,
    output logic              out_pair,
    output logic              out_acq,
    output logic              out_rel,
    output logic              out_bar_pre,
    output logic              out_bar_post,
    output logic              out_sp_chk,
    output logic [REG_W-1:0]  out_rt,
    output logic [REG_W-1:0]  out_rn,
    output logic [REG_W-1:0]  out_rt2,
    output logic [REG_W-1:0]  out_rs,
    output logic [SIZE_W-1:0] out_size
);
    logic [REG_W-1:0]  f_rt, f_rn, f_rt2, f_rs;
    logic [SIZE_W-1:0] f_size, f_eff_size;
    logic [IDX_W-1:0]  f_idx;
    logic              f_ord, f_load;
    logic              c_undef, c_pair;
    xo_op_e            c_op;
    logic              o_acq, o_rel, o_pre, o_post;
    xo_dec_t           dec_d, dec_q;

    assign f_rt   = in_insn[4:0];
    assign f_rn   = in_insn[9:5];
    assign f_rt2  = in_insn[14:10];
    assign f_ord  = in_insn[15];
    assign f_rs   = in_insn[20:16];
    assign f_load = in_insn[22];
    assign f_size = in_insn[31:30];
    assign f_idx  = {in_insn[23:21], f_ord};

    xo_class_decode u_class (
        .idx      (f_idx),
        .size     (f_size),
        .rt       (f_rt),
        .rs       (f_rs),
        .rt2      (f_rt2),
        .feat_en  (in_atomics_en),
        .op       (c_op),
        .undef    (c_undef),
        .pair     (c_pair),
        .eff_size (f_eff_size)
    );

    xo_order_ctl u_order (
        .op       (c_op),
        .ord_bit  (f_ord),
        .load_bit (f_load),
        .acq      (o_acq),
        .rel      (o_rel),
        .bar_pre  (o_pre),
        .bar_post (o_post)
    );

    always_comb begin
        dec_d = dec_q;
        dec_d.valid = in_valid;
        if (in_valid) begin
            dec_d.op       = c_op;
            dec_d.undef    = c_undef;
            dec_d.pair     = c_pair;
            dec_d.acq      = o_acq;
            dec_d.rel      = o_rel;
            dec_d.bar_pre  = o_pre;
            dec_d.bar_post = o_post;
            dec_d.sp_chk   = !c_undef && (f_rn == SP_REG);
            dec_d.rt       = f_rt;
            dec_d.rn       = f_rn;
            dec_d.rt2      = f_rt2;
            dec_d.rs       = f_rs;
            dec_d.size     = f_eff_size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid    = dec_q.valid;
    assign out_op       = dec_q.op;
    assign out_undef    = dec_q.undef;
    assign out_pair     = dec_q.pair;
    assign out_acq      = dec_q.acq;
    assign out_rel      = dec_q.rel;
    assign out_bar_pre  = dec_q.bar_pre;
    assign out_bar_post = dec_q.bar_post;
    assign out_sp_chk   = dec_q.sp_chk;
    assign out_rt       = dec_q.rt;
    assign out_rn       = dec_q.rn;
    assign out_rt2      = dec_q.rt2;
    assign out_rs       = dec_q.rs;
    assign out_size     = dec_q.size;
endmodule

// File: rtl/xo_decode_chk.sv
module xo_decode_chk
    import xo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_atomics_en,
    input logic              out_valid,
    input logic [2:0]        out_op,
    input logic              out_undef,
    input logic              out_pair,
    input logic              out_acq,
    input logic              out_rel,
    input logic              out_bar_pre,
    input logic              out_bar_post,
    input logic              out_sp_chk,
    input logic [REG_W-1:0]  out_rt,
    input logic [REG_W-1:0]  out_rn,
    input logic [REG_W-1:0]  out_rt2,
    input logic [REG_W-1:0]  out_rs,
    input logic [SIZE_W-1:0] out_size
);
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_op) && $stable(out_rn) &&
                      $stable(out_size) && $stable(out_undef));

    a_r9_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> out_op == 3'd0 && !out_pair && !out_acq && !out_rel &&
                      !out_bar_pre && !out_bar_post && !out_sp_chk);

    a_r8_cas_no_barrier: assert property (@(posedge clk) disable iff (!rst_n)
        (out_op == 3'd5 || out_op == 3'd6) |-> !out_bar_pre && !out_bar_post);

    a_r6_casp_regs: assert property (@(posedge clk) disable iff (!rst_n)
        out_op == 3'd6 |-> !out_rt[0] && !out_rs[0] && out_rt2 == SP_REG &&
                           out_size[1] && out_pair);

    a_r7_feature_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_op == 3'd5 || out_op == 3'd6) |-> $past(in_atomics_en));

    a_r10_sp_base: assert property (@(posedge clk) disable iff (!rst_n)
        out_sp_chk |-> out_rn == SP_REG && !out_undef);

    a_r2_one_barrier_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_bar_pre && out_bar_post));
endmodule

bind xo_decode_top xo_decode_chk u_chk (.*);

// File: tb/xo_decode_top_tb.sv
`timescale 1ns/1ps
module xo_decode_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic        in_atomics_en = 1'b0;
    logic        out_valid, out_undef, out_pair, out_acq, out_rel;
    logic        out_bar_pre, out_bar_post, out_sp_chk;
    logic [2:0]  out_op;
    logic [4:0]  out_rt, out_rn, out_rt2, out_rs;
    logic [1:0]  out_size;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xo_decode_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_atomics_en(in_atomics_en), .out_valid(out_valid), .out_op(out_op),
        .out_undef(out_undef), .out_pair(out_pair), .out_acq(out_acq),
        .out_rel(out_rel), .out_bar_pre(out_bar_pre), .out_bar_post(out_bar_post),
        .out_sp_chk(out_sp_chk), .out_rt(out_rt), .out_rn(out_rn),
        .out_rt2(out_rt2), .out_rs(out_rs), .out_size(out_size)
    );

    typedef struct packed {
        logic [2:0] op;
        logic       undef;
        logic       pair;
        logic       acq;
        logic       rel;
        logic       pre;
        logic       post;
        logic       sp;
        logic [1:0] size;
    } exp_t;

    function automatic exp_t model(input logic [31:0] w, input logic feat);
        exp_t e;
        logic [3:0] ix;
        logic lr, casok;
        ix = {w[23:21], w[15]};
        lr = w[15];
        e = '0;
        e.size = w[31:30];
        e.undef = 1'b1;
        if (ix == 0 || ix == 1) begin e.op = 1; e.rel = lr; e.pre = lr; e.undef = 0; end
        else if (ix == 4 || ix == 5) begin e.op = 2; e.acq = lr; e.post = lr; e.undef = 0; end
        else if (ix == 9) begin e.op = 3; e.rel = 1; e.pre = 1; e.undef = 0; end
        else if (ix == 13) begin e.op = 4; e.acq = 1; e.post = 1; e.undef = 0; end
        else if (ix == 2 || ix == 3 || ix == 6 || ix == 7) begin
            if (w[31]) begin
                e.undef = 0; e.pair = 1;
                if (ix >= 6) begin e.op = 2; e.acq = lr; e.post = lr; end
                else begin e.op = 1; e.rel = lr; e.pre = lr; end
            end else begin
                casok = feat && w[14:10] == 5'd31 && w[0] == 0 && w[16] == 0;
                if (casok) begin
                    e.undef = 0; e.op = 6; e.pair = 1; e.acq = w[22]; e.rel = lr;
                    e.size = {1'b1, w[30]};
                end
            end
        end else if (ix == 10 || ix == 11 || ix == 14 || ix == 15) begin
            if (feat && w[14:10] == 5'd31) begin
                e.undef = 0; e.op = 5; e.acq = w[22]; e.rel = lr;
            end
        end
        e.sp = !e.undef && w[9:5] == 5'd31;
        return e;
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        logic [3:0] ix;
        ix = {w[23:21], w[15]};
        if (ix == 0 || ix == 1) return "R2";
        if (ix == 4 || ix == 5) return "R3";
        if (ix == 9 || ix == 13) return "R4";
        if (ix == 8 || ix == 12) return "R9";
        if ((ix == 2 || ix == 3 || ix == 6 || ix == 7) && w[31]) return "R5";
        if (ix == 2 || ix == 3 || ix == 6 || ix == 7) return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [3:0] ix,
                                       input logic [4:0] rs, input logic [4:0] rt2,
                                       input logic [4:0] rn, input logic [4:0] rt);
        return {sz, 6'b001000, ix[3:1], rs, ix[0], rt2, rn, rt};
    endfunction

    task automatic run_one(input logic [31:0] w, input logic feat);
        exp_t e;
        exp_t a;
        @(negedge clk);
        in_insn = w;
        in_atomics_en = feat;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        e = model(w, feat);
        a = '{out_op, out_undef, out_pair, out_acq, out_rel, out_bar_pre,
              out_bar_post, out_sp_chk, out_size};
        // R11: result registered one edge later with valid pulse
        check(out_valid == 1'b1, "R11", {31'd0, out_valid}, 32'd1);
        // R1: field extraction
        check({out_rt, out_rn, out_rt2, out_rs} == {w[4:0], w[9:5], w[14:10], w[20:16]},
              "R1", {12'd0, out_rt, out_rn, out_rt2, out_rs},
              {12'd0, w[4:0], w[9:5], w[14:10], w[20:16]});
        // class, undefined flag, pair and size
        check({a.op, a.undef, a.pair, a.size} == {e.op, e.undef, e.pair, e.size},
              e.undef ? "R9" : tag_of(w), {25'd0, a.op, a.undef, a.pair, a.size},
              {25'd0, e.op, e.undef, e.pair, e.size});
        // ordering flags (R8 covers the CAS forms)
        check({a.acq, a.rel, a.pre, a.post} == {e.acq, e.rel, e.pre, e.post},
              (e.op == 5 || e.op == 6) ? "R8" : tag_of(w),
              {28'd0, a.acq, a.rel, a.pre, a.post}, {28'd0, e.acq, e.rel, e.pre, e.post});
        // R10: stack alignment check
        check(a.sp == e.sp, "R10", {31'd0, a.sp}, {31'd0, e.sp});
    endtask

    initial begin
        #4_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [31:0] held;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        check({out_valid, out_op, out_undef, out_size, out_rn} == '0, "R11",
              {19'd0, out_valid, out_op, out_undef, out_size, out_rn}, 32'd0);
        rst_n = 1'b1;

        // directed corners
        run_one(mk(2'd3, 4'd1, 5'd2, 5'd7, 5'd31, 5'd4), 1'b1);   // R2 STX release, SP base
        run_one(mk(2'd2, 4'd4, 5'd2, 5'd7, 5'd3, 5'd4), 1'b0);    // R3 plain LDX
        run_one(mk(2'd0, 4'd9, 5'd0, 5'd31, 5'd31, 5'd1), 1'b0);  // R4 store-release
        run_one(mk(2'd1, 4'd13, 5'd0, 5'd31, 5'd5, 5'd1), 1'b0);  // R4 load-acquire
        run_one(mk(2'd2, 4'd3, 5'd1, 5'd9, 5'd5, 5'd3), 1'b0);    // R5 STXP release
        run_one(mk(2'd3, 4'd6, 5'd1, 5'd9, 5'd5, 5'd3), 1'b0);    // R5 LDXP
        run_one(mk(2'd0, 4'd2, 5'd4, 5'd31, 5'd5, 5'd6), 1'b1);   // R6 CASP 32-bit -> size 2
        run_one(mk(2'd1, 4'd7, 5'd4, 5'd31, 5'd31, 5'd6), 1'b1);  // R6 CASPAL -> size 3
        run_one(mk(2'd0, 4'd2, 5'd4, 5'd31, 5'd5, 5'd7), 1'b1);   // R6 odd Rt -> undef
        run_one(mk(2'd0, 4'd2, 5'd5, 5'd31, 5'd5, 5'd6), 1'b1);   // R6 odd Rs -> undef
        run_one(mk(2'd0, 4'd2, 5'd4, 5'd30, 5'd5, 5'd6), 1'b1);   // R6 Rt2 != 31 -> undef
        run_one(mk(2'd0, 4'd2, 5'd4, 5'd31, 5'd31, 5'd6), 1'b0);  // R6 feature off
        run_one(mk(2'd3, 4'd15, 5'd3, 5'd31, 5'd8, 5'd9), 1'b1);  // R7 CASAL
        run_one(mk(2'd3, 4'd10, 5'd3, 5'd31, 5'd8, 5'd9), 1'b0);  // R7 feature off
        run_one(mk(2'd3, 4'd11, 5'd3, 5'd0, 5'd8, 5'd9), 1'b1);   // R7 Rt2 != 31
        run_one(mk(2'd3, 4'd8, 5'd3, 5'd31, 5'd31, 5'd9), 1'b1);  // R9 index 8
        run_one(mk(2'd1, 4'd12, 5'd3, 5'd31, 5'd31, 5'd9), 1'b1); // R9 index 12

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [4:0] rs, rt, rt2, rn;
            logic [3:0] ix;
            logic feat;
            w = $urandom;
            ix = 4'($urandom_range(0, 15));
            rs = 5'($urandom); rt = 5'($urandom); rt2 = 5'($urandom); rn = 5'($urandom);
            if ($urandom_range(0, 1) == 1) rt2 = 5'd31;
            if ($urandom_range(0, 1) == 1) begin rs[0] = 1'b0; rt[0] = 1'b0; end
            if ($urandom_range(0, 3) == 0) rn = 5'd31;
            feat = ($urandom_range(0, 3) != 0);
            w = {w[31:30], w[29:24], ix[3:1], rs, ix[0], rt2, rn, rt};
            run_one(w, feat);
        end

        // R11: outputs hold while valid is low
        held = {out_op, out_undef, out_pair, out_acq, out_rel, out_bar_pre,
                out_bar_post, out_sp_chk, out_rn, out_rt, out_size, 11'd0};
        @(negedge clk);
        in_insn = ~in_insn;
        in_atomics_en = ~in_atomics_en;
        @(negedge clk);
        check(out_valid == 1'b0, "R11", {31'd0, out_valid}, 32'd0);
        check({out_op, out_undef, out_pair, out_acq, out_rel, out_bar_pre,
               out_bar_post, out_sp_chk, out_rn, out_rt, out_size, 11'd0} == held, "R11",
              {out_op, out_undef, out_pair, out_acq, out_rel, out_bar_pre,
               out_bar_post, out_sp_chk, out_rn, out_rt, out_size, 11'd0}, held);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule